// File: doc/BRIEF.md
# Four-Phase Interleaved PWM Controller with Minimum-Time Level Changes

This block drives the four gate signals of an open-loop, four-phase interleaved buck stage. In steady state every phase switches with the same duty cycle, and each phase lags the one before it by a quarter of the switching period. The duty cycle takes one of four discrete levels: one, two, three or four quarters of the period.

A new level arrives as a request on a valid/ready stream. The request is acted on at the boundary of a phase-1 switching period. If it asks for a different level, the controller stops normal switching and runs one timed step. In that step every phase switches on once and off once. Each phase has its own on-time, and all phases share one step length. These timings come from a writable table indexed by the old and new levels. When the step ends, interleaved PWM resumes at the new level with the quarter-period offsets restored.

Software or a quantizer loads the table through a plain write port. The `busy` flag marks the timed step.

Top module: `mphase_mintime_pwm`

## Requirements
- R1: Level code L (0..3) selects duty (L+1)/4. In PWM mode, phase k (k = 0..3, k = 0 being phase 1) is high while its position, (cycles since the period start − k·PERIOD/4) mod PERIOD, is below (L+1)·PERIOD/4. After reset the level is 0 and phase 1 sits at position 0, so the gate vector is 4'b0001.
- R2: A request is accepted on a cycle where `req_valid` and `req_ready` are both high. One request is held at a time. `req_ready` is low while a request is held, and a source under back-pressure must keep its request stable until it is accepted.
- R3: A held request is examined only on the last cycle of a phase-1 period. If it names a new level, the timed step starts on the next cycle.
- R4: A held request naming the current level is consumed without starting a step, and PWM continues without any break.
- R5: During a step, phase k is high for cycles 0 .. ton_k−1 of the step and low after that. No phase rises more than once within a step.
- R6: A step length of 0 in the table is treated as a step of one cycle.
- R7: `busy` is high on exactly the cycles of a step.
- R8: On the cycle after a step ends, PWM restarts at the new level with phase 1 at position 0 and the other phases at their quarter-period offsets.
- R9: The table address is {old level, new level}, with the old level in the upper two bits. In a table word, the on-time of phase k sits at bits [k·TW +: TW] and the step length at [4·TW +: TW]. All values count clock cycles.
- R10: A request accepted while a step runs is held. It is applied at the first phase-1 period boundary after the step ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Level request valid |
| req_ready | output | 1 | Level request can be accepted |
| req_level | input | 2 | Requested level code |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 4 | Table write address {old, new} |
| tbl_wdata | input | 5·TW | Four on-times and a step length |
| gate | output | 4 | Phase gate drives, bit k = phase k+1 |
| busy | output | 1 | Timed step in progress |

## Verification
The hardest situation to reach from the ports is a request that waits through a whole timed step. While it waits, a second request is stalled by back-pressure, and the first must then be applied at a boundary that lies some distance after the step ends. The bench reaches this by issuing level requests back to back, in a sweep over all sixteen {old, new} pairs. This makes every second request arrive during a step or while one is already held. The table entries use varied on-times, some longer than the step, plus one zero-length step, so the clipping and minimum-length cases arise inside the same sweep.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_STEP = 1'b1
  } mode_e;
endpackage

// File: rtl/mmt_phase_ctr.sv
module mmt_phase_ctr #(
  parameter int PERIOD = 100,
  parameter int CW     = 7,
  parameter int INIT   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          reload,
  output logic [CW-1:0] pos
);
  localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] START = CW'(INIT);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      pos <= START;
    end else if (run) begin
      pos <= (pos == LAST) ? '0 : pos + CW'(1);
    end
  end
endmodule

// File: rtl/mmt_seq_table.sv
module mmt_seq_table #(
  parameter int AW = 4,
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/mmt_sequencer.sv
module mmt_sequencer
  import mmt_pkg::*;
#(
  parameter int PERIOD = 100,
  parameter int CW     = 7,
  parameter int LW     = 2,
  parameter int TW     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [LW-1:0]   req_level,
  input  logic [CW-1:0]   pos0,
  input  logic [TW-1:0]   step_len,
  output mode_e           mode,
  output logic [LW-1:0]   cur_lvl,
  output logic [TW-1:0]   step_cyc,
  output logic            rd_en,
  output logic [2*LW-1:0] rd_addr,
  output logic            ctr_run,
  output logic            ctr_reload
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          hold_v;
  logic [LW-1:0] hold_lvl;
  logic          boundary, decide, change, step_done, accept;

  assign req_ready  = !hold_v;
  assign accept     = req_valid && req_ready;
  assign boundary   = (pos0 == LAST);
  assign decide     = (mode == MODE_PWM) && hold_v && boundary;
  assign change     = decide && (hold_lvl != cur_lvl);
  assign rd_en      = change;
  assign rd_addr    = {cur_lvl, hold_lvl};
  assign step_done  = (mode == MODE_STEP) &&
                      ((TW+1)'(step_cyc) + (TW+1)'(1) >= (TW+1)'(step_len));
  assign ctr_run    = (mode == MODE_PWM);
  assign ctr_reload = step_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v   <= 1'b0;
      hold_lvl <= '0;
    end else if (decide) begin
      hold_v   <= 1'b0;
    end else if (accept) begin
      hold_v   <= 1'b1;
      hold_lvl <= req_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_PWM;
      cur_lvl  <= '0;
      step_cyc <= '0;
    end else if (change) begin
      mode     <= MODE_STEP;
      cur_lvl  <= hold_lvl;
      step_cyc <= '0;
    end else if (step_done) begin
      mode     <= MODE_PWM;
      step_cyc <= '0;
    end else if (mode == MODE_STEP) begin
      step_cyc <= step_cyc + TW'(1);
    end
  end
endmodule

// File: rtl/mphase_mintime_pwm.sv
module mphase_mintime_pwm
  import mmt_pkg::*;
#(
  parameter int PERIOD = 100,
  parameter int NPH    = 4,
  parameter int TW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [$clog2(NPH)-1:0] req_level,
  input  logic                 tbl_we,
  input  logic [2*$clog2(NPH)-1:0] tbl_addr,
  input  logic [(NPH+1)*TW-1:0] tbl_wdata,
  output logic [NPH-1:0]       gate,
  output logic                 busy
);
  localparam int LW   = $clog2(NPH);
  localparam int AW   = 2 * LW;
  localparam int DW   = (NPH + 1) * TW;
  localparam int CW   = $clog2(PERIOD + 1);
  localparam int SLOT = PERIOD / NPH;

  mode_e           mode;
  logic [LW-1:0]   cur_lvl;
  logic [TW-1:0]   step_cyc;
  logic            rd_en, ctr_run, ctr_reload;
  logic [AW-1:0]   rd_addr;
  logic [DW-1:0]   rd_word;
  logic [CW-1:0]   pos [NPH];
  logic [CW-1:0]   pos0;
  logic [CW-1:0]   on_len;

  assign pos0   = pos[0];
  assign on_len = CW'((32'(cur_lvl) + 1) * SLOT);
  assign busy   = (mode == MODE_STEP);

  mmt_sequencer #(.PERIOD(PERIOD), .CW(CW), .LW(LW), .TW(TW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_level  (req_level),
    .pos0       (pos0),
    .step_len   (rd_word[NPH*TW +: TW]),
    .mode       (mode),
    .cur_lvl    (cur_lvl),
    .step_cyc   (step_cyc),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .ctr_run    (ctr_run),
    .ctr_reload (ctr_reload)
  );

  mmt_seq_table #(.AW(AW), .DW(DW)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    mmt_phase_ctr #(
      .PERIOD (PERIOD),
      .CW     (CW),
      .INIT   ((PERIOD - k * SLOT) % PERIOD)
    ) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .run    (ctr_run),
      .reload (ctr_reload),
      .pos    (pos[k])
    );

    assign gate[k] = busy ? (step_cyc < rd_word[k*TW +: TW])
                          : (pos[k] < on_len);
  end
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
  parameter int PERIOD = 100,
  parameter int NPH    = 4,
  parameter int CW     = 7,
  parameter int LW     = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [NPH-1:0] gate,
  input logic           busy,
  input logic           req_valid,
  input logic           req_ready,
  input logic [CW-1:0]  pos0,
  input logic [LW-1:0]  cur_lvl
);
  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_start_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(pos0) == CW'(PERIOD - 1)));

  assert_one_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((gate & ~$past(gate)) == '0));

  assert_resume_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (pos0 == '0 && gate[0]));

  assert_quarter_duty_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && cur_lvl == '0) |-> $onehot0(gate));
endmodule

bind mphase_mintime_pwm mmt_checker #(
  .PERIOD (PERIOD),
  .NPH    (NPH),
  .CW     ($clog2(PERIOD + 1)),
  .LW     ($clog2(NPH))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gate      (gate),
  .busy      (busy),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .pos0      (pos0),
  .cur_lvl   (cur_lvl)
);

// File: tb/sim_mphase_mintime_pwm.sv
module sim_mphase_mintime_pwm;
  localparam int P = 16, NPH = 4, TW = 8, Q = P / 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, req_valid, req_ready, tbl_we, busy;
  logic [1:0] req_level;
  logic [3:0] tbl_addr, gate;
  logic [(NPH+1)*TW-1:0] tbl_wdata;

  mphase_mintime_pwm #(.PERIOD(P), .NPH(NPH), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_level(req_level), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .gate(gate), .busy(busy)
  );

  int vecs = 0, fails = 0;
  int tbl_on [16][4];
  int tbl_dt [16];
  int m_step, m_pos, m_lvl, m_hv, m_hl, m_dt, m_fresh, m_same, m_late;
  int m_on [4];
  bit last_acc;

  function automatic void chk(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  task automatic step();
    int eg, eb, er;
    string tg;
    eg = 0;
    for (int k = 0; k < 4; k++) begin
      if (m_step) eg |= ((m_pos < m_on[k]) ? 1 : 0) << k;
      else eg |= ((((m_pos - k*Q + P) % P) < (m_lvl+1)*Q) ? 1 : 0) << k;
    end
    eb = m_step;
    er = !m_hv;
    if (m_step) tg = (m_dt == 0) ? "R6" : "R5/R9";
    else if (m_fresh) tg = "R8";
    else if (m_same) tg = "R4";
    else tg = "R1";
    chk(gate == eg[3:0], tg, gate, eg);
    chk(busy == eb[0], (m_step && m_pos == 0) ? (m_late ? "R10" : "R3") : "R7", busy, eb);
    chk(req_ready == er[0], "R2", req_ready, er);
    // advance the reference to the next edge
    last_acc = req_valid && !m_hv;
    if (!m_step) begin
      if (m_hv && m_pos == P-1) begin
        m_hv = 0;
        m_late = 0;
        if (m_hl != m_lvl) begin
          m_step = 1;
          for (int k = 0; k < 4; k++) m_on[k] = tbl_on[m_lvl*4 + m_hl][k];
          m_dt = tbl_dt[m_lvl*4 + m_hl];
          m_lvl = m_hl;
          m_pos = 0;
          m_same = 0;
          m_fresh = 0;
        end else begin
          m_same = 1;
          m_pos = 0;
        end
      end else begin
        if (m_pos == P-1) begin m_fresh = 0; m_same = 0; end
        m_pos = (m_pos + 1) % P;
      end
    end else begin
      if (m_pos + 1 >= m_dt) begin
        m_step = 0; m_pos = 0; m_fresh = 1;
      end else m_pos++;
    end
    if (last_acc) begin
      m_hv = 1; m_hl = req_level;
      if (m_step) m_late = 1;
    end
    if (tbl_we) begin
      for (int k = 0; k < 4; k++) tbl_on[tbl_addr][k] = tbl_wdata[k*TW +: TW];
      tbl_dt[tbl_addr] = tbl_wdata[4*TW +: TW];
    end
    @(negedge clk);
  endtask

  task automatic send(int lvl);
    req_valid = 1'b1;
    req_level = 2'(lvl);
    do step(); while (!last_acc);
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_level = '0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    m_step = 0; m_pos = 0; m_lvl = 0; m_hv = 0; m_hl = 0; m_dt = 1;
    m_fresh = 0; m_same = 0; m_late = 0;
    for (int k = 0; k < 4; k++) m_on[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state, R1 and R2
    chk(gate == 4'b0001, "R1", gate, 1);
    chk(busy == 1'b0, "R7", busy, 0);
    chk(req_ready == 1'b1, "R2", req_ready, 1);
    // load table, R9 field layout; entry {1,3} gets a zero step (R6)
    for (int a = 0; a < 16; a++) begin
      int o, n;
      o = a >> 2; n = a & 3;
      tbl_we = 1'b1;
      tbl_addr = 4'(a);
      for (int k = 0; k < 4; k++) tbl_wdata[k*TW +: TW] = TW'(1 + ((o*5 + n*3 + k*2) % 11));
      tbl_wdata[4*TW +: TW] = (a == 7) ? '0 : TW'(6 + o + n*2);
      step();
    end
    tbl_we = 1'b0;
    // sweep every {old,new} pair with back-to-back requests (R3, R4, R10)
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        send(o);
        send(n);
        repeat (o + n) step();
      end
    end
    repeat (3 * P + 32) step();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule